// File: doc/BRIEF.md
# Memory-Side Atomic Operation Unit

This block owns a small word-addressed register memory and serves several requesters through it. Each requester presents a request on its own valid/ready port. The request carries an opcode, a word address and two operands. The unit accepts at most one request per clock. When several requesters are valid together, the lowest requester index wins. The winning request's read and write both happen in the same clock, so no other access can fall between them.

Besides plain load and store, the unit performs these operations: compare-and-swap, test-and-set, fetch-and-increment, and a load-linked / store-conditional pair. Each requester holds a single link reservation, made of a valid bit and a word address. A load-linked sets the requester's reservation. Any write to a word clears every reservation on that word. A store-conditional writes only while its issuer's reservation still covers the addressed word. In every case the store-conditional drops the issuer's reservation.

One clock after a request is accepted, a single response appears. It carries the requester index and a data word. For store-conditional the data word is the success flag. For every other opcode it is the value the word held before the operation.

Top module: `atomic_unit`

## Requirements
- R1: After reset every memory word reads 0, no reservation is held, rsp_valid_o is low and no ready is high while no request is valid.
- R2: In any cycle at most one req_ready_o bit is high. It is the bit of the lowest-indexed requester whose req_valid_i is high, and a request is accepted when its valid and ready are both high.
- R3: rsp_valid_o is high in exactly the cycle after an acceptance, and rsp_id_o then holds the accepted requester index.
- R4: Opcode 0 (load) returns the word. Opcode 1 (store) writes operand A and returns the previous word.
- R5: Opcode 2 (compare-and-swap) returns the previous word. It writes operand B only when the previous word equals operand A.
- R6: Opcode 3 (test-and-set) writes operand A and returns the previous word.
- R7: Opcode 4 (fetch-and-increment) writes the word plus one, wrapping from all ones to zero, and returns the previous word.
- R8: Opcode 5 (load-linked) returns the word and sets the issuer's reservation to that address. Opcode 6 (store-conditional) succeeds only when the issuer holds a reservation on the same address. On success it writes operand A and returns 1. On failure it writes nothing and returns 0.
- R9: Every write clears all reservations on the written address. Writes elsewhere, loads and a compare-and-swap that does not match leave reservations intact.
- R10: A store-conditional clears its issuer's reservation whether it succeeds or fails.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_REQ | Request valid per requester |
| req_ready_o | output | N_REQ | Request accepted, one-hot or zero |
| req_op_i | input | N_REQ x 3 | Opcode per requester |
| req_addr_i | input | N_REQ x ADDR_W | Word address per requester |
| req_opa_i | input | N_REQ x DATA_W | Operand A per requester |
| req_opb_i | input | N_REQ x DATA_W | Operand B per requester |
| rsp_valid_o | output | 1 | Response valid |
| rsp_id_o | output | ID_W | Index of the requester being answered |
| rsp_data_o | output | DATA_W | Previous word, or the store-conditional success flag |

## Verification
The hardest case to reach is a reservation that is lost because another requester writes between a load-linked and its store-conditional. Two variants matter most: several reservations on one word dropped by a single write, and a reservation that must survive a failed compare-and-swap to the same word. Directed sequences build each of these interleavings explicitly. They also drive simultaneous valids so that arbitration by index orders the operations. After that, a long random phase confines addresses to four words and operand A to four values. This makes link races and matching compare-and-swaps frequent, and a behavioural model follows every response.

// File: rtl/atomic_pkg.sv
package atomic_pkg;
  localparam int OP_W = 3;
  typedef enum logic [OP_W-1:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_CAS   = 3'd2,
    OP_TAS   = 3'd3,
    OP_FAI   = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6
  } atomic_op_e;
endpackage

// File: rtl/atomic_arb.sv
module atomic_arb #(
  parameter int N_REQ = 4,
  localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0] valid_i,
  output logic [N_REQ-1:0] grant_o,
  output logic [ID_W-1:0]  id_o,
  output logic             any_o
);
  always_comb begin
    grant_o = '0;
    id_o    = '0;
    any_o   = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (valid_i[i] && !any_o) begin
        grant_o[i] = 1'b1;
        id_o       = ID_W'(i);
        any_o      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/atomic_alu.sv
module atomic_alu
  import atomic_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  atomic_op_e        op_i,
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic              sc_ok_i,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    we_o    = 1'b0;
    wdata_o = opa_i;
    rdata_o = old_i;
    unique case (op_i)
      OP_STORE: we_o = 1'b1;
      OP_CAS: begin
        we_o    = (old_i == opa_i);
        wdata_o = opb_i;
      end
      OP_TAS: we_o = 1'b1;
      OP_FAI: begin
        we_o    = 1'b1;
        wdata_o = old_i + DATA_W'(1);
      end
      OP_SC: begin
        we_o    = sc_ok_i;
        rdata_o = {{(DATA_W-1){1'b0}}, sc_ok_i};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/atomic_resv.sv
module atomic_resv
  import atomic_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  localparam int ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic [ID_W-1:0]   id_i,
  input  atomic_op_e        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              sc_ok_o
);
  logic              v_q [N_REQ];
  logic [ADDR_W-1:0] a_q [N_REQ];

  for (genvar g = 0; g < N_REQ; g++) begin : g_slot
    logic mine;
    assign mine = (id_i == ID_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[g] <= 1'b0;
        a_q[g] <= '0;
      end else if (fire_i) begin
        if (mine && op_i == OP_LL) begin
          v_q[g] <= 1'b1;
          a_q[g] <= addr_i;
        end else if (mine && op_i == OP_SC) begin
          v_q[g] <= 1'b0;
        end else if (we_i && a_q[g] == addr_i) begin
          v_q[g] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    sc_ok_o = 1'b0;
    for (int i = 0; i < N_REQ; i++)
      if (id_i == ID_W'(i)) sc_ok_o = v_q[i] && (a_q[i] == addr_i);
  end
endmodule

// File: rtl/atomic_unit.sv
module atomic_unit
  import atomic_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  localparam int ID_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [N_REQ-1:0]              req_valid_i,
  output logic [N_REQ-1:0]              req_ready_o,
  input  logic [N_REQ-1:0][OP_W-1:0]    req_op_i,
  input  logic [N_REQ-1:0][ADDR_W-1:0]  req_addr_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_opa_i,
  input  logic [N_REQ-1:0][DATA_W-1:0]  req_opb_i,
  output logic                          rsp_valid_o,
  output logic [ID_W-1:0]               rsp_id_o,
  output logic [DATA_W-1:0]             rsp_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  logic [ID_W-1:0]   gnt_id;
  logic              fire;
  atomic_op_e        s_op;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_opa, s_opb, old_word, wdata, rdata;
  logic              we, sc_ok;

  atomic_arb #(.N_REQ(N_REQ)) u_arb (
    .valid_i (req_valid_i),
    .grant_o (req_ready_o),
    .id_o    (gnt_id),
    .any_o   (fire)
  );

  always_comb begin
    s_op   = OP_LOAD;
    s_addr = '0;
    s_opa  = '0;
    s_opb  = '0;
    for (int i = 0; i < N_REQ; i++) begin
      if (gnt_id == ID_W'(i)) begin
        s_op   = atomic_op_e'(req_op_i[i]);
        s_addr = req_addr_i[i];
        s_opa  = req_opa_i[i];
        s_opb  = req_opb_i[i];
      end
    end
  end

  assign old_word = mem_q[s_addr];

  atomic_resv #(.N_REQ(N_REQ), .ADDR_W(ADDR_W)) u_resv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .id_i    (gnt_id),
    .op_i    (s_op),
    .addr_i  (s_addr),
    .we_i    (we),
    .sc_ok_o (sc_ok)
  );

  atomic_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i    (s_op),
    .old_i   (old_word),
    .opa_i   (s_opa),
    .opb_i   (s_opb),
    .sc_ok_i (sc_ok),
    .we_o    (we),
    .wdata_o (wdata),
    .rdata_o (rdata)
  );

  // read and write share the granted cycle: the RMW is indivisible
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (fire && we) begin
      mem_q[s_addr] <= wdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_id_o    <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= fire;
      if (fire) begin
        rsp_id_o   <= gnt_id;
        rsp_data_o <= rdata;
      end
    end
  end
endmodule

// File: rtl/atomic_unit_chk.sv
module atomic_unit_chk #(
  parameter int N_REQ = 4,
  localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REQ-1:0] req_valid_i,
  input logic [N_REQ-1:0] req_ready_o,
  input logic             rsp_valid_o,
  input logic [ID_W-1:0]  rsp_id_o
);
  logic [ID_W-1:0] acc_id;
  logic            acc;
  always_comb begin
    acc_id = '0;
    for (int i = 0; i < N_REQ; i++)
      if (req_ready_o[i]) acc_id = ID_W'(i);
  end
  assign acc = |(req_valid_i & req_ready_o);

  p_onehot_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(req_ready_o));
  p_ready_needs_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o & ~req_valid_i) == '0);
  p_no_lower_waiting_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_ready_o != '0) |-> ((req_valid_i & (req_ready_o - 1'b1)) == '0));
  p_valid_grants_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i != '0) |-> (req_ready_o != '0));
  p_rsp_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> (rsp_valid_o && rsp_id_o == $past(acc_id)));
  p_no_spurious_rsp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !rsp_valid_o);
endmodule

bind atomic_unit atomic_unit_chk #(.N_REQ(N_REQ)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rsp_id_o    (rsp_id_o)
);

// File: tb/atomic_unit_bench.sv
`timescale 1ns/1ps
module atomic_unit_bench;
  localparam int N = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int LD = 0, ST = 1, CAS = 2, TAS = 3, FAI = 4, LL = 5, SC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]         vld = '0;
  logic [N-1:0]         rdy;
  logic [N-1:0][2:0]    opv = '0;
  logic [N-1:0][AW-1:0] adv = '0;
  logic [N-1:0][DW-1:0] av = '0, bv = '0;
  logic          rsp_v;
  logic [1:0]    rsp_id;
  logic [DW-1:0] rsp_d;

  always #4 clk = ~clk;

  atomic_unit u_atomic_unit (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(vld), .req_ready_o(rdy),
    .req_op_i(opv), .req_addr_i(adv), .req_opa_i(av), .req_opb_i(bv),
    .rsp_valid_o(rsp_v), .rsp_id_o(rsp_id), .rsp_data_o(rsp_d));

  int vectors = 0, fails = 0, last_win;
  logic [DW-1:0] mem_m [1<<AW];
  bit            rv [N];
  logic [AW-1:0] ra [N];

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic mwrite(logic [AW-1:0] ad, logic [DW-1:0] val);
    mem_m[ad] = val;
    for (int j = 0; j < N; j++) if (rv[j] && ra[j] == ad) rv[j] = 0;
  endtask

  // inputs are set at posedge+1; ready checked at posedge+2, response at next posedge+1
  task automatic step();
    int w = -1;
    logic [DW-1:0] ed = '0, old;
    logic [N-1:0]  er = '0;
    string tg = "R4";
    bit ok;
    for (int i = 0; i < N; i++) if (vld[i] && w < 0) w = i;
    last_win = w;
    if (w >= 0) er[w] = 1'b1;
    #1;
    chk(rdy == er, "R2 ready", DW'(rdy), DW'(er));
    if (w >= 0) begin
      old = mem_m[adv[w]];
      ed = old;
      case (int'(opv[w]))
        ST:  mwrite(adv[w], av[w]);
        CAS: begin tg = "R5"; if (old == av[w]) mwrite(adv[w], bv[w]); end
        TAS: begin tg = "R6"; mwrite(adv[w], av[w]); end
        FAI: begin tg = "R7"; mwrite(adv[w], old + 1); end
        LL:  begin tg = "R8"; rv[w] = 1; ra[w] = adv[w]; end
        SC: begin
          tg = "R8 R9 R10 sc";
          ok = rv[w] && ra[w] == adv[w];
          ed = DW'(ok);
          if (ok) mwrite(adv[w], av[w]);
          rv[w] = 0;
        end
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk(rsp_v == (w >= 0), "R3 valid", DW'(rsp_v), DW'(w >= 0));
    if (w >= 0) begin
      chk(rsp_id == 2'(w), "R3 id", DW'(rsp_id), DW'(w));
      chk(rsp_d == ed, tg, rsp_d, ed);
    end
  endtask

  task automatic setr(int id, int op, int ad, logic [DW-1:0] a = '0, logic [DW-1:0] b = '0);
    vld[id] = 1'b1; opv[id] = 3'(op); adv[id] = AW'(ad); av[id] = a; bv[id] = b;
  endtask

  task automatic issue(int id, int op, int ad, logic [DW-1:0] a = '0, logic [DW-1:0] b = '0);
    vld = '0;
    setr(id, op, ad, a, b);
    step();
    vld = '0;
  endtask

  task automatic drain();
    while (vld != '0) begin
      step();
      if (last_win >= 0) vld[last_win] = 1'b0;
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem_m[i] = '0;
    for (int i = 0; i < N; i++) begin rv[i] = 0; ra[i] = '0; end
    #21 rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: reset state
    chk(rsp_v == 1'b0, "R1 rsp_valid", DW'(rsp_v), 0);
    #1 chk(rdy == '0, "R1 ready", DW'(rdy), 0);
    @(posedge clk); #1;
    issue(2, LD, 11);
    chk(rsp_d == '0, "R1 mem zero", rsp_d, 0);
    issue(0, SC, 0, 32'h77);
    chk(rsp_d == '0, "R1 no reservation", rsp_d, 0);
    issue(1, LD, 0);
    step();  // idle cycle, R3 no response
    // R4 store/load
    issue(0, ST, 3, 32'h55);
    issue(1, LD, 3);
    // R5 compare-and-swap match then mismatch
    issue(2, CAS, 3, 32'h55, 32'hAA);
    issue(2, CAS, 3, 32'h55, 32'h11);
    issue(3, LD, 3);
    // R6 test-and-set twice
    issue(3, TAS, 5, 32'h1);
    issue(0, TAS, 5, 32'h1);
    // R7 wrap
    issue(0, ST, 7, 32'hFFFF_FFFF);
    issue(1, FAI, 7);
    issue(1, FAI, 7);
    issue(2, LD, 7);
    // R8 success, R10 second SC fails
    issue(1, LL, 8);
    issue(1, SC, 8, 32'h99);
    issue(1, LD, 8);
    issue(1, SC, 8, 32'h98);
    // R10 failed SC also drops the link
    issue(2, LL, 4);
    issue(2, SC, 6, 32'h1);
    issue(2, SC, 4, 32'h2);
    // R9 one write breaks two links
    issue(1, LL, 8);
    issue(2, LL, 8);
    issue(0, ST, 8, 32'h5);
    issue(1, SC, 8, 32'h6);
    issue(2, SC, 8, 32'h7);
    issue(3, LD, 8);
    // R9 non-writes and other addresses keep the link
    issue(1, LL, 9);
    issue(0, ST, 10, 32'h3);
    issue(0, CAS, 9, 32'h1234, 32'h1);
    issue(3, LD, 9);
    issue(1, SC, 9, 32'hC0);
    // R8 address mismatch
    issue(3, LL, 9);
    issue(3, SC, 10, 32'h1);
    // R2 priority: 1 before 3, then all four
    vld = '0; setr(3, LD, 9); setr(1, ST, 9, 32'h42); drain();
    setr(3, FAI, 2); setr(2, FAI, 2); setr(0, FAI, 2); setr(1, FAI, 2); drain();
    // random phase over four words
    for (int c = 0; c < 3000; c++) begin
      for (int i = 0; i < N; i++) begin
        vld[i] = ($urandom % 3) != 0;
        opv[i] = 3'($urandom % 7);
        adv[i] = AW'($urandom % 4);
        av[i]  = DW'($urandom % 4);
        bv[i]  = $urandom;
      end
      step();
    end
    vld = '0;
    step();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule